// File: doc/BRIEF.md
# Profiling Control Register Access Arbiter

This block decides the fate of a software access to a privileged profiling control register. Each cycle it looks at three groups of inputs: the privilege level that issued the access and whether it reads or writes; which privilege levels exist and are enabled; and the configuration bits that can block or divert the access. It then names exactly one outcome: undefined instruction, trap to level 2, trap to level 3, redirect to a memory slot, or direct register access. For the two trap outcomes it also provides the exception class. For the redirect outcome it provides the memory offset.

The decision is a fixed priority chain. Checks that make the access undefined early come first. The level-2 traps (fine-grained, then coarse) come next. The late level-3 checks follow, and these yield undefined or a level-3 trap depending on a select input. The memory redirect comes last. The result is held in a registered outcome state, so the outputs show the decision for the inputs that were present one clock edge earlier. Exception entry is left to the surrounding pipeline.

The outcome state takes five named values: DENY (undefined), TRAP_L2, TRAP_L3, MEM (redirect) and DIRECT. Every cycle the state register moves from any value to any value, with the priority chain applied to that cycle's inputs. Reset forces DENY.

Top module: `ptrap_arbiter`

## Requirements
- R1: Exactly one of res_undef, res_trap_l2, res_trap_l3, res_redirect, res_direct is 1 in every cycle. The outputs reflect the inputs sampled at the previous rising clock edge. During and after reset, before the first decision, res_undef is the one asserted.
- R2: An access with req_el = 0 (binary level encoding, 0 to 3) gives res_undef.
- R3: An access with req_el = 3 gives res_direct when cfg_has_l3 = 1. An access from a level that is not implemented gives res_undef: level 2 with cfg_has_l2 = 0, or level 3 with cfg_has_l3 = 0.
- R4: At levels 1 and 2, the ownership check fails when cfg_has_l3 = 1 and at least one of these holds: own_lo = 0; own_hi differs from sec_state; or realm_ext = 1 and own_ext differs from sec_ext. A failed check with early_undef = 1 gives res_undef, and this check has the highest priority.
- R5: At levels 1 and 2, when cfg_has_l3 = 1, l3_prof_en = 0 and early_undef = 1, the result is res_undef. This check ranks below R4 and above every trap.
- R6: At level 1, level 2 is active when cfg_has_l2 = 1 and l2_on = 1. When level 2 is active, fg_present = 1, and either cfg_has_l3 = 0 or fg_l3_en = 1, a direction pass bit of 0 gives res_trap_l2. The pass bit is fg_rd_pass for reads (req_write = 0) and fg_wr_pass for writes.
- R7: At level 1, with level 2 active and l2_coarse_trap = 1, the result is res_trap_l2 unless R4, R5 or R6 decided first.
- R8: When the R4 ownership check fails or l3_prof_en = 0 with cfg_has_l3 = 1, and no earlier rule decided, the result is res_undef if undef_sel = 1 and res_trap_l3 otherwise.
- R9: res_syndrome equals 0x18 while res_trap_l2 or res_trap_l3 is 1, and 0 otherwise.
- R10: At level 1, with level 2 active and no earlier rule deciding, nv_mode[2] = 1 with nv_mode[0] = 1 gives res_redirect, and nv_mode[1] has no effect. res_offset is 0x850 while res_redirect is 1 and 0 otherwise. All remaining level-1 and level-2 accesses give res_direct.
- R11: At level 2, neither the level-2 trap checks nor the memory redirect apply, so res_trap_l2 and res_redirect are never the result for req_el = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_el | input | 2 | Privilege level of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_has_l2 | input | 1 | Level 2 is implemented |
| cfg_has_l3 | input | 1 | Level 3 is implemented |
| l2_on | input | 1 | Level 2 is enabled in the current state |
| own_lo | input | 1 | Ownership bit 0 |
| own_hi | input | 1 | Ownership bit 1, compared with sec_state |
| sec_state | input | 1 | Current security-state bit |
| realm_ext | input | 1 | Realm extension present |
| own_ext | input | 1 | Extended ownership bit |
| sec_ext | input | 1 | Extended security-state bit |
| l3_prof_en | input | 1 | Level-3 profiling enable |
| early_undef | input | 1 | Early-undefined priority override |
| undef_sel | input | 1 | Late check yields undefined instead of level-3 trap |
| fg_present | input | 1 | Fine-grained traps implemented |
| fg_l3_en | input | 1 | Level-3 permission for fine-grained traps |
| fg_rd_pass | input | 1 | Read pass bit (0 traps reads) |
| fg_wr_pass | input | 1 | Write pass bit (0 traps writes) |
| l2_coarse_trap | input | 1 | Coarse level-2 trap |
| nv_mode | input | 3 | Nested-virtualization mode bits |
| res_undef | output | 1 | Outcome: undefined |
| res_trap_l2 | output | 1 | Outcome: trap to level 2 |
| res_trap_l3 | output | 1 | Outcome: trap to level 3 |
| res_redirect | output | 1 | Outcome: redirect to memory |
| res_direct | output | 1 | Outcome: direct register access |
| res_syndrome | output | 6 | Exception class for traps |
| res_offset | output | 12 | Memory offset for redirect |

## Verification
The bench uses the default parameters: a 6-bit syndrome of 0x18 and a 12-bit offset of 0x850. Because the block has no depth parameter, the sweep covers the decision inputs directly. Folding a few inputs onto their neighbours leaves 17 free bits, and the bench applies all 131072 combinations. This reaches every priority ordering between the early checks, the two level-2 traps, the late level-3 checks and the redirect, for both directions and for every privilege level. Directed cases then pin the ordering boundaries, such as a fine-grained trap losing to the early-undefined override.

// File: rtl/ptrap_pkg.sv
package ptrap_pkg;

    typedef enum logic [2:0] {
        OC_DENY   = 3'd0,
        OC_TRAP2  = 3'd1,
        OC_TRAP3  = 3'd2,
        OC_MEM    = 3'd3,
        OC_DIRECT = 3'd4
    } outcome_e;

    localparam int unsigned OC_COUNT = 5;

    typedef struct packed {
        logic own_lo;
        logic own_hi;
        logic sec_state;
        logic realm_ext;
        logic own_ext;
        logic sec_ext;
    } own_bits_t;

endpackage

// File: rtl/ptrap_own_check.sv
module ptrap_own_check
    import ptrap_pkg::*;
(
    input  logic      has_l3,
    input  own_bits_t own,
    input  logic      l3_prof_en,
    output logic      own_fail,
    output logic      pen_off
);
    logic hi_mismatch;
    logic ext_mismatch;

    always_comb begin
        hi_mismatch  = own.own_hi ^ own.sec_state;
        ext_mismatch = own.realm_ext & (own.own_ext ^ own.sec_ext);
        own_fail     = has_l3 & (~own.own_lo | hi_mismatch | ext_mismatch);
        pen_off      = has_l3 & ~l3_prof_en;
    end
endmodule

// File: rtl/ptrap_prio_chain.sv
module ptrap_prio_chain
    import ptrap_pkg::*;
(
    input  logic [1:0] el,
    input  logic       is_write,
    input  logic       has_l2,
    input  logic       has_l3,
    input  logic       l2_on,
    input  logic       own_fail,
    input  logic       pen_off,
    input  logic       early_undef,
    input  logic       undef_sel,
    input  logic       fg_present,
    input  logic       fg_l3_en,
    input  logic       fg_rd_pass,
    input  logic       fg_wr_pass,
    input  logic       coarse_trap,
    input  logic [2:0] nv_mode,
    output outcome_e   next_out
);
    logic     l2_act;
    logic     fg_hit;
    logic     redir_hit;
    logic     late_hit;
    outcome_e late_out;

    always_comb begin
        l2_act    = has_l2 & l2_on;
        fg_hit    = l2_act & fg_present & (~has_l3 | fg_l3_en)
                  & ~(is_write ? fg_wr_pass : fg_rd_pass);
        redir_hit = l2_act & nv_mode[2] & nv_mode[0];
        late_hit  = own_fail | pen_off;
        late_out  = undef_sel ? OC_DENY : OC_TRAP3;
    end

    always_comb begin
        next_out = OC_DENY;
        unique case (el)
            2'd0: next_out = OC_DENY;
            2'd1: begin
                if (own_fail & early_undef)     next_out = OC_DENY;
                else if (pen_off & early_undef) next_out = OC_DENY;
                else if (fg_hit)                next_out = OC_TRAP2;
                else if (l2_act & coarse_trap)  next_out = OC_TRAP2;
                else if (late_hit)              next_out = late_out;
                else if (redir_hit)             next_out = OC_MEM;
                else                            next_out = OC_DIRECT;
            end
            2'd2: begin
                if (!has_l2)                    next_out = OC_DENY;
                else if (own_fail & early_undef) next_out = OC_DENY;
                else if (pen_off & early_undef) next_out = OC_DENY;
                else if (late_hit)              next_out = late_out;
                else                            next_out = OC_DIRECT;
            end
            2'd3: next_out = has_l3 ? OC_DIRECT : OC_DENY;
            default: next_out = OC_DENY;
        endcase
    end
endmodule

// File: rtl/ptrap_arbiter.sv
module ptrap_arbiter
    import ptrap_pkg::*;
#(
    parameter int unsigned              SYN_W      = 6,
    parameter logic [SYN_W-1:0]         TRAP_CLASS = 6'h18,
    parameter int unsigned              OFF_W      = 12,
    parameter logic [OFF_W-1:0]         REDIR_OFF  = 12'h850
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_el,
    input  logic             req_write,
    input  logic             cfg_has_l2,
    input  logic             cfg_has_l3,
    input  logic             l2_on,
    input  logic             own_lo,
    input  logic             own_hi,
    input  logic             sec_state,
    input  logic             realm_ext,
    input  logic             own_ext,
    input  logic             sec_ext,
    input  logic             l3_prof_en,
    input  logic             early_undef,
    input  logic             undef_sel,
    input  logic             fg_present,
    input  logic             fg_l3_en,
    input  logic             fg_rd_pass,
    input  logic             fg_wr_pass,
    input  logic             l2_coarse_trap,
    input  logic [2:0]       nv_mode,
    output logic             res_undef,
    output logic             res_trap_l2,
    output logic             res_trap_l3,
    output logic             res_redirect,
    output logic             res_direct,
    output logic [SYN_W-1:0] res_syndrome,
    output logic [OFF_W-1:0] res_offset
);
    localparam int unsigned NOUT = OC_COUNT;

    own_bits_t       own_vec;
    logic            own_fail;
    logic            pen_off;
    outcome_e        next_out;
    outcome_e        state_q;
    logic [NOUT-1:0] sel_vec;

    assign own_vec = '{own_lo: own_lo, own_hi: own_hi, sec_state: sec_state,
                       realm_ext: realm_ext, own_ext: own_ext, sec_ext: sec_ext};

    ptrap_own_check u_own (
        .has_l3     (cfg_has_l3),
        .own        (own_vec),
        .l3_prof_en (l3_prof_en),
        .own_fail   (own_fail),
        .pen_off    (pen_off)
    );

    ptrap_prio_chain u_chain (
        .el          (req_el),
        .is_write    (req_write),
        .has_l2      (cfg_has_l2),
        .has_l3      (cfg_has_l3),
        .l2_on       (l2_on),
        .own_fail    (own_fail),
        .pen_off     (pen_off),
        .early_undef (early_undef),
        .undef_sel   (undef_sel),
        .fg_present  (fg_present),
        .fg_l3_en    (fg_l3_en),
        .fg_rd_pass  (fg_rd_pass),
        .fg_wr_pass  (fg_wr_pass),
        .coarse_trap (l2_coarse_trap),
        .nv_mode     (nv_mode),
        .next_out    (next_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OC_DENY;
        else        state_q <= next_out;
    end

    // outputs
    for (genvar gi = 0; gi < NOUT; gi++) begin : g_sel
        assign sel_vec[gi] = (state_q == outcome_e'(gi));
    end

    always_comb begin
        res_undef    = sel_vec[OC_DENY];
        res_trap_l2  = sel_vec[OC_TRAP2];
        res_trap_l3  = sel_vec[OC_TRAP3];
        res_redirect = sel_vec[OC_MEM];
        res_direct   = sel_vec[OC_DIRECT];
        res_syndrome = (sel_vec[OC_TRAP2] | sel_vec[OC_TRAP3]) ? TRAP_CLASS : '0;
        res_offset   = sel_vec[OC_MEM] ? REDIR_OFF : '0;
    end
endmodule

// File: rtl/ptrap_arbiter_chk.sv
module ptrap_arbiter_chk #(
    parameter int unsigned      SYN_W      = 6,
    parameter logic [SYN_W-1:0] TRAP_CLASS = 6'h18,
    parameter int unsigned      OFF_W      = 12,
    parameter logic [OFF_W-1:0] REDIR_OFF  = 12'h850
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       req_el,
    input logic             cfg_has_l2,
    input logic             cfg_has_l3,
    input logic             l3_prof_en,
    input logic             early_undef,
    input logic             res_undef,
    input logic             res_trap_l2,
    input logic             res_trap_l3,
    input logic             res_redirect,
    input logic             res_direct,
    input logic [SYN_W-1:0] res_syndrome,
    input logic [OFF_W-1:0] res_offset
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_undef, res_trap_l2, res_trap_l3, res_redirect, res_direct}) == 1); // R1
    AST_LEVEL0_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_el == 2'd0) |=> res_undef); // R2
    AST_LEVEL3_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_el == 2'd3 && cfg_has_l3) |=> res_direct); // R3
    AST_ABSENT_L2_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_el == 2'd2 && !cfg_has_l2) |=> res_undef); // R3
    AST_EARLY_PEN_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_el == 2'd1 && cfg_has_l3 && early_undef && !l3_prof_en) |=> res_undef); // R5
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_trap_l2 || res_trap_l3) |-> res_syndrome == TRAP_CLASS); // R9
    AST_NO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_trap_l2 || res_trap_l3) |-> res_syndrome == '0); // R9
    AST_REDIR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        res_redirect |-> res_offset == REDIR_OFF); // R10
    AST_LEVEL2_NO_L2PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_el == 2'd2) |=> !(res_trap_l2 || res_redirect)); // R11
endmodule

bind ptrap_arbiter ptrap_arbiter_chk #(
    .SYN_W(SYN_W), .TRAP_CLASS(TRAP_CLASS), .OFF_W(OFF_W), .REDIR_OFF(REDIR_OFF)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_el       (req_el),
    .cfg_has_l2   (cfg_has_l2),
    .cfg_has_l3   (cfg_has_l3),
    .l3_prof_en   (l3_prof_en),
    .early_undef  (early_undef),
    .res_undef    (res_undef),
    .res_trap_l2  (res_trap_l2),
    .res_trap_l3  (res_trap_l3),
    .res_redirect (res_redirect),
    .res_direct   (res_direct),
    .res_syndrome (res_syndrome),
    .res_offset   (res_offset)
);

// File: tb/ptrap_arbiter_tb.sv
module ptrap_arbiter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req_el = '0;
    logic req_write = 0, cfg_has_l2 = 0, cfg_has_l3 = 0, l2_on = 0;
    logic own_lo = 0, own_hi = 0, sec_state = 0, realm_ext = 0, own_ext = 0, sec_ext = 0;
    logic l3_prof_en = 0, early_undef = 0, undef_sel = 0, fg_present = 0, fg_l3_en = 0;
    logic fg_rd_pass = 0, fg_wr_pass = 0, l2_coarse_trap = 0;
    logic [2:0] nv_mode = '0;
    logic res_undef, res_trap_l2, res_trap_l3, res_redirect, res_direct;
    logic [5:0]  res_syndrome;
    logic [11:0] res_offset;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ptrap_arbiter u_dut (.*);

    // expected outcome code: 0 undef, 1 trap2, 2 trap3, 3 redirect, 4 direct
    // tag names the requirement that decided
    function automatic int model(output string tag);
        bit ofail, poff, act2, fgt;
        ofail = cfg_has_l3 && (!own_lo || own_hi != sec_state || (realm_ext && own_ext != sec_ext));
        poff  = cfg_has_l3 && !l3_prof_en;
        act2  = cfg_has_l2 && l2_on;
        fgt   = act2 && fg_present && (!cfg_has_l3 || fg_l3_en) &&
                ((req_write && !fg_wr_pass) || (!req_write && !fg_rd_pass));
        if (req_el == 0) begin tag = "R2"; return 0; end
        if (req_el == 3) begin tag = "R3"; return cfg_has_l3 ? 4 : 0; end
        if (req_el == 2 && !cfg_has_l2) begin tag = "R3"; return 0; end
        if (ofail && early_undef) begin tag = "R4"; return 0; end
        if (poff && early_undef) begin tag = "R5"; return 0; end
        if (req_el == 1 && fgt) begin tag = "R6"; return 1; end
        if (req_el == 1 && act2 && l2_coarse_trap) begin tag = "R7"; return 1; end
        if (ofail || poff) begin tag = "R8"; return undef_sel ? 0 : 2; end
        if (req_el == 1 && act2 && nv_mode[2] && nv_mode[0]) begin tag = "R10"; return 3; end
        tag = (req_el == 2) ? "R11" : "R10";
        return 4;
    endfunction

    task automatic check_out(input int exp_code, input string tag);
        logic [4:0] act, exp;
        logic [5:0] exp_syn;
        logic [11:0] exp_off;
        act = {res_direct, res_redirect, res_trap_l3, res_trap_l2, res_undef};
        exp = 5'b1 << exp_code;
        exp_syn = (exp_code == 1 || exp_code == 2) ? 6'h18 : 6'h0;
        exp_off = (exp_code == 3) ? 12'h850 : 12'h0;
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s el=%0d outcome actual=%b expected=%b", tag, req_el, act, exp);
        end else if (res_syndrome !== exp_syn) begin
            errors++;
            $display("FAIL R9 syndrome actual=%h expected=%h", res_syndrome, exp_syn);
        end else if (res_offset !== exp_off) begin
            errors++;
            $display("FAIL R10 offset actual=%h expected=%h", res_offset, exp_off);
        end
    endtask

    // apply current inputs, wait one edge, compare at negedge
    task automatic step_check();
        string tag;
        int    e;
        e = model(tag);
        @(posedge clk);
        @(negedge clk);
        check_out(e, tag);
    endtask

    task automatic apply_vec(input logic [16:0] v);
        req_el         = v[1:0];
        req_write      = v[2];
        l2_on          = v[3];
        cfg_has_l3     = v[4];
        own_lo         = v[5];
        sec_state      = v[6];
        own_hi         = v[6] ^ v[7];
        realm_ext      = v[8];
        own_ext        = v[9];
        sec_ext        = v[9] ^ v[7] ^ v[10];
        l3_prof_en     = v[11];
        early_undef    = v[12];
        undef_sel      = v[13];
        fg_present     = v[14];
        fg_l3_en       = v[15];
        fg_rd_pass     = v[16];
        fg_wr_pass     = ~v[16] ^ v[10];
        l2_coarse_trap = v[7] ^ v[12];
        cfg_has_l2     = v[3] | v[8];
        nv_mode        = {v[2] ^ v[13], v[5], v[11] ^ v[14]};
    endtask

    task automatic clean_l1();
        req_el = 2'd1; req_write = 0; cfg_has_l2 = 1; cfg_has_l3 = 1; l2_on = 1;
        own_lo = 1; own_hi = 0; sec_state = 0; realm_ext = 0; own_ext = 0; sec_ext = 0;
        l3_prof_en = 1; early_undef = 0; undef_sel = 0; fg_present = 1; fg_l3_en = 1;
        fg_rd_pass = 1; fg_wr_pass = 1; l2_coarse_trap = 0; nv_mode = 3'b000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state is undefined
        checks++;
        if ({res_direct, res_redirect, res_trap_l3, res_trap_l2, res_undef} !== 5'b00001) begin
            errors++;
            $display("FAIL R1 reset outcome actual=%b expected=00001",
                     {res_direct, res_redirect, res_trap_l3, res_trap_l2, res_undef});
        end
        rst_n = 1'b1;

        // directed ordering cases
        clean_l1();                         step_check(); // R10 direct
        nv_mode = 3'b101;                   step_check(); // R10 redirect
        nv_mode = 3'b111;                   step_check(); // R10 middle bit ignored
        req_write = 1; fg_wr_pass = 0;      step_check(); // R6 write trap beats redirect
        fg_wr_pass = 1; fg_rd_pass = 0;     step_check(); // R6 read bit ignored on write -> redirect
        l2_coarse_trap = 1;                 step_check(); // R7 coarse trap
        own_lo = 0; undef_sel = 0;          step_check(); // R7 still wins over R8
        l2_coarse_trap = 0;                 step_check(); // R8 trap to level 3
        early_undef = 1; fg_wr_pass = 0;    step_check(); // R4 early beats fine trap
        own_lo = 1; l3_prof_en = 0;         step_check(); // R5 early enable
        req_el = 2'd2; early_undef = 0; undef_sel = 1; step_check(); // R8 undefined select
        l3_prof_en = 1; l2_coarse_trap = 1; step_check(); // R11 level 2 skips trap
        req_el = 2'd3;                      step_check(); // R3
        req_el = 2'd0;                      step_check(); // R2

        // near-exhaustive sweep
        for (int i = 0; i < (1 << 17); i++) begin
            apply_vec(17'(i));
            step_check();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule